// File: doc/BRIEF.md
# Reset Cause and Software Reset Controller

This block holds one 64-bit register on a simple read/write bus. The register records why the most recent reset happened. It also lets software start a power-on-class reset or raise a trap request for an externally initiated reset.

Two active-low reset inputs come from outside the clock domain: a processor power-on reset and an externally initiated reset. Both pass through a two-flop synchronizer. The active-low system power-on input is the block's own asynchronous reset, and it is the only signal that initializes the stored bits. The processor and external reset inputs do not initialize them.

Every source that is active during a reset episode is noted. When the episode ends, only the highest-priority source is written into the cause bits, and any earlier cause is replaced. The order from highest to lowest is: system input, software power-on request, processor power-on input, external reset input, software external-reset request. The software bits stay set through the reset they cause, until software writes them back to 0.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The register responds only when `req_i` is high and `addr_i` equals `REG_ADDR` (default 0x1FE0000F020). Any other address reads as zero, and a write to it changes no bit and starts no pulse.
- R2: Bits 63:32 and 26:0 always read as zero, and writing ones to them has no effect.
- R3: After the system power-on input (`rst_ni`) is released, the register reads 0x80000000, and `soft_rst_o` and `trap_req_o` are low.
- R4: Bits 31, 28 and 27 are write-1-to-clear. Writing 0 to any of them leaves it unchanged.
- R5: When a processor power-on reset episode ends (`por_ni` released) and no higher-priority source was active, bit 28 becomes 1 and bits 31 and 27 become 0.
- R6: When an external reset episode ends (`xrst_ni` released) and it was the only source, bit 27 becomes 1 and bits 31 and 28 become 0.
- R7: When several sources overlap in one episode, only the highest-priority source is recorded, whatever the order of release. A software power-on request leaves bits 31, 28 and 27 all at 0 and is recorded by bit 30 itself.
- R8: Bit 30 is read/write. A 0-to-1 change of bit 30 drives `soft_rst_o` high for exactly `PULSE_LEN` (16) cycles. Writing 1 while it is already 1 starts no pulse. The bit keeps its value through that reset.
- R9: Bit 29 is read/write. A 0-to-1 change of bit 29 drives `trap_req_o` high for exactly one cycle and drives no reset. Writing 1 while it is already 1 raises nothing.
- R10: If a cause capture and a write-1-to-clear of the same bit fall in the same cycle, the capture wins and the bit reads 1.
- R11: Processor and external reset episodes do not change bits 30 and 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System power-on reset, active low, asynchronous |
| por_ni | input | 1 | Processor power-on reset, active low, asynchronous to clk_i |
| xrst_ni | input | 1 | Externally initiated reset, active low, asynchronous to clk_i |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, combinational, zero when not selected |
| soft_rst_o | output | 1 | Reset pulse caused by the software power-on request |
| trap_req_o | output | 1 | One-cycle trap request for the software external-reset bit |

## Verification
The assertions assume that each external reset input stays low for at least two clock cycles, so the synchronizer sees every episode. They also assume that a bus access lasts exactly one cycle with stable address and data. The bench drives both inputs on falling edges, holds each reset low for four or more cycles, and releases each strobe after one rising edge. For the same-cycle conflict test, the write is timed to land on the edge where the synchronized release ends the episode.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int DATA_W = 64;
  // bit positions decoded by software
  localparam int B_SYS  = 31;
  localparam int B_SPOR = 30;
  localparam int B_SXIR = 29;
  localparam int B_PPOR = 28;
  localparam int B_XRST = 27;

  typedef struct packed {
    logic spor;
    logic ppor;
    logic xrst;
  } src_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // inputs are active low: idle value is 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  // a start that arrives while the pulse is running is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    else if (start_i)          cnt_q <= CNT_W'(LEN);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pulse_i,
  input  logic              por_n_i,
  input  logic              xrst_n_i,
  output logic [DATA_W-1:0] reg_o,
  output logic              cap_o,
  output logic [1:0]        cap_val_o,
  output logic              spor_start_o,
  output logic              trap_o
);
  src_t now_s, seen_q, seen_nxt;
  logic win_q, win_now;
  logic [2:0] cause_q, hw_cause, w1c;   // {sys, ppor, xrst}
  logic spor_q, sxir_q, sxir_d1_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:32], wdata_i[26:0]};

  always_comb begin
    now_s.spor = pulse_i;
    now_s.ppor = ~por_n_i;
    now_s.xrst = ~xrst_n_i;
  end

  assign win_now  = |now_s;
  assign seen_nxt = src_t'((win_q ? seen_q : src_t'('0)) | now_s);
  assign cap_o    = win_q & ~win_now;

  // highest recorded source wins when the episode ends
  always_comb begin
    if (seen_q.spor)      hw_cause = 3'b000;
    else if (seen_q.ppor) hw_cause = 3'b010;
    else                  hw_cause = 3'b001;
  end
  assign cap_val_o = hw_cause[1:0];

  assign w1c = wr_i ? {wdata_i[B_SYS], wdata_i[B_PPOR], wdata_i[B_XRST]} : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= 1'b0;
      seen_q    <= '0;
      cause_q   <= 3'b100;
      spor_q    <= 1'b0;
      sxir_q    <= 1'b0;
      sxir_d1_q <= 1'b0;
    end else begin
      win_q     <= win_now;
      seen_q    <= seen_nxt;
      if (cap_o) cause_q <= hw_cause;            // set beats clear
      else       cause_q <= cause_q & ~w1c;
      if (wr_i) begin
        spor_q <= wdata_i[B_SPOR];
        sxir_q <= wdata_i[B_SXIR];
      end
      sxir_d1_q <= sxir_q;
    end
  end

  assign spor_start_o = wr_i & wdata_i[B_SPOR] & ~spor_q;
  assign trap_o       = sxir_q & ~sxir_d1_q;

  always_comb begin
    reg_o         = '0;
    reg_o[B_SYS]  = cause_q[2];
    reg_o[B_SPOR] = spor_q;
    reg_o[B_SXIR] = sxir_q;
    reg_o[B_PPOR] = cause_q[1];
    reg_o[B_XRST] = cause_q[0];
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int              ADDR_W    = 41,
  parameter logic [ADDR_W-1:0] REG_ADDR = 41'h1FE_0000_F020,
  parameter int              PULSE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              xrst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              soft_rst_o,
  output logic              trap_req_o
);
  logic              hit, wr;
  logic [DATA_W-1:0] reg_q;
  logic              cap;
  logic [1:0]        cap_val;
  logic              spor_start;
  logic [1:0]        ext_sync;

  assign hit = req_i && (addr_i == REG_ADDR);
  assign wr  = hit & we_i;

  rcc_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({por_ni, xrst_ni}),
    .q_o   (ext_sync)
  );

  rcc_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(spor_start),
    .busy_o (soft_rst_o)
  );

  rcc_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .wdata_i     (wdata_i),
    .pulse_i     (soft_rst_o),
    .por_n_i     (ext_sync[1]),
    .xrst_n_i    (ext_sync[0]),
    .reg_o       (reg_q),
    .cap_o       (cap),
    .cap_val_o   (cap_val),
    .spor_start_o(spor_start),
    .trap_o      (trap_req_o)
  );

  assign rdata_o = (hit && !we_i) ? reg_q : '0;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int PULSE_LEN = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] reg_i,
  input logic [63:0] rdata_i,
  input logic        soft_rst_i,
  input logic        trap_i,
  input logic        wr_i,
  input logic        w31_i,
  input logic        cap_i,
  input logic [1:0]  cap_val_i
);
  localparam int CW = $clog2(PULSE_LEN + 2);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hi_cnt <= '0;
    else if (!soft_rst_i)                hi_cnt <= '0;
    else if (hi_cnt != CW'(PULSE_LEN+1)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[63:32] == '0 && rdata_i[26:0] == '0); // R2

  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cap_i && reg_i[31] && !w31_i) |=> reg_i[31]); // R4

  AST_CAP_PPOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && cap_val_i[1]) |=> (reg_i[28] && !reg_i[27] && !reg_i[31])); // R5

  AST_CAP_XRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && cap_val_i[0]) |=> (reg_i[27] && !reg_i[28] && !reg_i[31])); // R6

  AST_CAUSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_i[31], reg_i[28], reg_i[27]})); // R7

  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> hi_cnt < CW'(PULSE_LEN)); // R8

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_i) |-> hi_cnt == CW'(PULSE_LEN)); // R8

  AST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_i) |-> reg_i[30]); // R8

  AST_TRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !trap_i); // R9

  AST_TRAP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> (reg_i[29] && !$past(reg_i[29]))); // R9

  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && wr_i && cap_val_i[0]) |=> reg_i[27]); // R10
endmodule

bind rst_cause_ctrl rcc_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_i     (reg_q),
  .rdata_i   (rdata_o),
  .soft_rst_i(soft_rst_o),
  .trap_i    (trap_req_o),
  .wr_i      (wr),
  .w31_i     (wdata_i[31]),
  .cap_i     (cap),
  .cap_val_i (cap_val)
);

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
  localparam logic [40:0] REG_A = 41'h1FE_0000_F020;
  localparam logic [63:0] M31 = 64'h8000_0000;
  localparam logic [63:0] M30 = 64'h4000_0000;
  localparam logic [63:0] M29 = 64'h2000_0000;
  localparam logic [63:0] M28 = 64'h1000_0000;
  localparam logic [63:0] M27 = 64'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b1, xrst_n = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [40:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        soft_rst, trap;
  int n_cmp = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_cause_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .xrst_ni(xrst_n),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .soft_rst_o(soft_rst), .trap_req_o(trap)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [40:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic brd(input logic [40:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic cnt_out(input int n, output int nr, output int nt);
    nr = 0; nt = 0;
    for (int i = 0; i < n; i++) begin
      if (soft_rst) nr++;
      if (trap) nt++;
      @(negedge clk);
    end
  endtask

  task automatic ext_pulse(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else xrst_n = 1'b0;
    idle(5);
    por_n = 1'b1; xrst_n = 1'b1;
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int nr, nt;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R3 power-up state
    brd(REG_A, d); chk("R3 initial", d, M31);
    chk("R3 outputs idle", {62'd0, soft_rst, trap}, 64'd0);

    // R1 address decode sweep: one flipped address bit at a time
    for (int b = 0; b < 41; b++) begin
      bwr(REG_A ^ (41'd1 << b), '1);
      brd(REG_A ^ (41'd1 << b), d);
      chk($sformatf("R1 foreign addr bit %0d", b), d, 64'd0);
    end
    cnt_out(20, nr, nt);
    chk("R1 no pulse from foreign writes", 64'(nr + nt), 64'd0);
    brd(REG_A, d); chk("R1 register untouched", d, M31);

    // R2, R4: reserved ones and zero on W1C bits
    bwr(REG_A, ~(M31 | M30 | M29 | M28 | M27));
    brd(REG_A, d); chk("R2 R4 reserved ignored, write 0 keeps cause", d, M31);
    bwr(REG_A, M31);
    brd(REG_A, d); chk("R4 W1C bit31", d, 64'd0);

    // R6 external reset
    ext_pulse(1'b0);
    brd(REG_A, d); chk("R6 external cause", d, M27);
    // R5 processor power-on overwrites earlier cause
    ext_pulse(1'b1);
    brd(REG_A, d); chk("R5 processor cause", d, M28);

    // R7 overlap sweep over both sources and release order
    for (int m = 1; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        @(negedge clk);
        por_n = !((m & 2) != 0); xrst_n = !((m & 1) != 0);
        idle(4);
        if (o == 0) por_n = 1'b1; else xrst_n = 1'b1;
        idle(3);
        por_n = 1'b1; xrst_n = 1'b1;
        idle(8);
        brd(REG_A, d);
        chk($sformatf("R7 overlap m=%0d o=%0d", m, o), d, ((m & 2) != 0) ? M28 : M27);
      end
    end

    // R10 capture and clear on the same edge
    bwr(REG_A, M31 | M28 | M27);
    brd(REG_A, d); chk("R4 W1C all causes", d, 64'd0);
    @(negedge clk) xrst_n = 1'b0;
    idle(5);
    xrst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = REG_A; wdata = M27;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    idle(3);
    brd(REG_A, d); chk("R10 set wins over clear", d, M27);
    bwr(REG_A, M27);
    brd(REG_A, d); chk("R4 W1C bit27", d, 64'd0);

    // R8 software power-on request
    bwr(REG_A, M30);
    cnt_out(40, nr, nt);
    chk("R8 pulse length", 64'(nr), 64'd16);
    brd(REG_A, d); chk("R8 R7 soft bit kept, causes clear", d, M30);
    bwr(REG_A, M30);
    cnt_out(30, nr, nt);
    chk("R8 rewrite 1 no pulse", 64'(nr), 64'd0);
    bwr(REG_A, 64'd0);
    brd(REG_A, d); chk("R8 software clears bit30", d, 64'd0);
    // soft request overlapping an external episode
    @(negedge clk) xrst_n = 1'b0;
    idle(4);
    bwr(REG_A, M30);
    idle(5);
    xrst_n = 1'b1;
    idle(30);
    brd(REG_A, d); chk("R7 soft outranks external", d, M30);

    // R9 software trap request
    bwr(REG_A, M30 | M29);
    cnt_out(20, nr, nt);
    chk("R9 trap single cycle", 64'(nt), 64'd1);
    chk("R9 no reset from trap bit", 64'(nr), 64'd0);
    brd(REG_A, d); chk("R9 bit29 reads back", d, M30 | M29);
    bwr(REG_A, M30 | M29);
    cnt_out(20, nr, nt);
    chk("R9 rewrite 1 no trap", 64'(nt), 64'd0);
    bwr(REG_A, M30);
    bwr(REG_A, M30 | M29);
    cnt_out(20, nr, nt);
    chk("R9 trap after 0 to 1 again", 64'(nt), 64'd1);

    // R11 software bits survive a processor episode
    ext_pulse(1'b1);
    brd(REG_A, d); chk("R11 soft bits kept through processor reset", d, M30 | M29 | M28);
    ext_pulse(1'b0);
    brd(REG_A, d); chk("R11 soft bits kept through external reset", d, M30 | M29 | M27);

    // R3 system input reinitializes everything
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    brd(REG_A, d); chk("R3 after system reset", d, M31);
    chk("R3 outputs idle after reset", {62'd0, soft_rst, trap}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule